// File: doc/BRIEF.md
# Supply Monitor Duty-Cycle Controller

This block keeps the supply comparators mostly powered down. It counts periods of a slow 32 kHz tick. Once per interval it raises an enable strobe to the low-voltage-detect comparator and the power-on-reset comparator. The strobe lasts exactly one slow period. At the tick that closes that period, the block samples both comparator outputs and stores them in a status register. The comparator outputs are first passed through a two-flop synchronizer.

A 2-bit duty-cycle code in a trim register chooses the interval length. The mapping is deliberately not monotonic in the code value. Writing the trim register restarts the interval count.

Both registers sit in a secondary I/O bank behind a simple CPU port. They answer only while the extended-I/O flag is set.

Top module: `supmon_duty_ctrl`

## Requirements
- R1: After reset the trim register reads 0x00, the status register reads 0x00 and `cmp_en` is low.
- R2: The duty code selects the interval length N in slow ticks: code 2'b00 gives N=128, 2'b01 gives N=512, 2'b10 gives N=32 and 2'b11 gives N=8. Counting ticks from the last restart, `cmp_en` is high after tick k exactly when k is a nonzero multiple of N. It therefore stays high for one slow period out of every N.
- R3: Out of reset, with code 2'b00, the first enable begins at the 128th slow tick.
- R4: Any write to the trim register restarts the count, so the next enable comes N ticks after the write under the new code. If a window is open at the time of the write, it closes without updating the status.
- R5: The tick that ends an enable window loads status bit 1 with the synchronized low-voltage-detect input and status bit 0 with the synchronized power-on-reset input. A 1 means tripped and a 0 means no event.
- R6: Between capture ticks the status register holds its value, whatever the comparator inputs do.
- R7: The trim register is at address 0x1EB. Bits 7:6 are the read/write duty code. Bits 5:0 read 0 and ignore writes.
- R8: The status register is at address 0x1E4. It is read-only, with bits 7:2 reading 0, and a write to it changes nothing.
- R9: While `xio_en` is low, writes to either address have no effect and reads return 0x00.
- R10: Reads of any other address return 0x00.
- R11: A comparator input is used only after two clock edges of synchronization. A change made one clock before the closing tick is not captured until the following window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lstick | input | 1 | One-clock pulse per 32 kHz period |
| xio_en | input | 1 | Extended-I/O bank flag; gates all register access |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| lvd_trip_in | input | 1 | Raw low-voltage-detect comparator output (asynchronous) |
| por_trip_in | input | 1 | Raw power-on-reset comparator output (asynchronous) |
| cmp_en | output | 1 | Comparator power-up strobe |

## Verification
The hardest case to reach from the ports is a window that closes while a comparator input is still moving through the synchronizer. Another hard case is a window that is cut off by a trim write before its closing tick. For the first, the bench changes an input exactly one clock before the closing tick and expects the previous value to be captured. For the second, it rewrites the trim register while `cmp_en` is high and confirms that the status is unchanged and the count restarts. A table of codes and input levels walks all four intervals in a scrambled order. Each row's expected status differs from the row before it, so a missed or early capture shows up at the port.

// File: rtl/supmon_pkg.sv
`timescale 1ns/1ps
// supmon_pkg: shared constants, duty-code type and the interval mapping for
// the supply monitor duty-cycle controller.
// Assumes the longest interval fits in CNT_W bits.
package supmon_pkg;

    localparam int DATA_W   = 8;
    localparam int CODE_W   = 2;
    localparam int CNT_W    = 9;
    localparam int STAT_W   = 2;
    localparam int CODE_LSB = DATA_W - CODE_W;

    typedef enum logic [CODE_W-1:0] {
        DUTY_128 = 2'b00,
        DUTY_512 = 2'b01,
        DUTY_32  = 2'b10,
        DUTY_8   = 2'b11
    } duty_code_e;

    // Terminal count (interval minus one) for a duty code.
    function automatic logic [CNT_W-1:0] last_count(duty_code_e code);
        logic [CNT_W-1:0] r;
        case (code)
            DUTY_128: r = CNT_W'(127);
            DUTY_512: r = CNT_W'(511);
            DUTY_32:  r = CNT_W'(31);
            default:  r = CNT_W'(7);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/supmon_sync.sv
`timescale 1ns/1ps
// supmon_sync: two-flop synchronizer, one independent chain per bit.
// Assumes inputs are level signals that change slowly relative to clk.
module supmon_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q;
        logic stab_q;

        // Shift the raw level through two flops.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_i[b];
                stab_q <= meta_q;
            end
        end

        assign sync_o[b] = stab_q;
    end

endmodule

// File: rtl/supmon_window.sv
`timescale 1ns/1ps
// supmon_window: counts slow ticks and opens a one-period enable window
// every N ticks, with N taken from the duty code. It pulses capture on
// the tick that closes a window. A restart clears the count and any open
// window. Assumes tick_i is a one-clock pulse and that code_i changes
// only in the same cycle as restart_i.
module supmon_window
    import supmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       restart_i,
    input  duty_code_e code_i,
    output logic       en_o,
    output logic       capture_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             en_q;
    logic [CNT_W-1:0] term;

    // Terminal count for the current code.
    always_comb term = last_count(code_i);

    // Advance the period count and open or close the window on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else if (restart_i) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else if (tick_i) begin
            if (cnt_q == term) begin
                cnt_q <= '0;
                en_q  <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                en_q  <= 1'b0;
            end
        end
    end

    assign en_o      = en_q;
    assign capture_o = tick_i & en_q & ~restart_i;

    // R2: the count never passes the terminal value of the active code.
    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= term);

    // R2: an open window closes on the next tick.
    p_window_one_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && tick_i) |=> !en_q);

    // R2: a window opens only on a tick.
    p_open_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !tick_i) |=> !en_q);

    // R4: a restart clears both the count and the window.
    p_restart_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (!en_q && cnt_q == '0));

endmodule

// File: rtl/supmon_regs.sv
`timescale 1ns/1ps
// supmon_regs: the register port in the secondary I/O bank. It holds the
// R/W trim register (duty code in the top bits) and the read-only status
// register loaded on capture. Assumes a single-cycle access strobe; read
// data is combinational in the strobe cycle.
module supmon_regs
    import supmon_pkg::*;
#(
    parameter int          ADDR_W    = 9,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 9'h1E4,
    parameter logic [ADDR_W-1:0] TRIM_ADDR = 9'h1EB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xio_en,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              capture_i,
    input  logic [STAT_W-1:0] cmp_sync_i,
    output duty_code_e        code_o,
    output logic              restart_o
);

    duty_code_e        code_q;
    logic [STAT_W-1:0] stat_q;
    logic              trim_wr;
    logic              rd_ok;
    logic              wdata_unused;

    // Qualified trim write.
    assign trim_wr      = bus_sel & bus_we & xio_en & (bus_addr == TRIM_ADDR);
    assign rd_ok        = bus_sel & ~bus_we & xio_en;
    assign wdata_unused = &{1'b0, bus_wdata[CODE_LSB-1:0]};

    // Store the duty code on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= DUTY_128;
        end else if (trim_wr) begin
            code_q <= duty_code_e'(bus_wdata[DATA_W-1:CODE_LSB]);
        end
    end

    // Load the comparator results when the window closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (capture_i) begin
            stat_q <= cmp_sync_i;
        end
    end

    // Read mux; gated reads and unknown addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            if (bus_addr == TRIM_ADDR) begin
                bus_rdata = {code_q, {CODE_LSB{1'b0}}};
            end else if (bus_addr == STAT_ADDR) begin
                bus_rdata = {{(DATA_W-STAT_W){1'b0}}, stat_q};
            end
        end
    end

    assign code_o    = code_q;
    assign restart_o = trim_wr;

    // R6: status changes only on a capture pulse.
    p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(stat_q));

    // R9: the code holds unless a qualified trim write occurs.
    p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_o |=> $stable(code_q));

endmodule

// File: rtl/supmon_duty_ctrl.sv
`timescale 1ns/1ps
// supmon_duty_ctrl: top of the supply monitor duty-cycle controller.
// Ties together the synchronizer, the window timer and the register port.
// Assumes lstick is a one-clock pulse in the clk domain and that the
// comparator outputs are asynchronous levels.
module supmon_duty_ctrl
    import supmon_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lstick,
    input  logic              xio_en,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              lvd_trip_in,
    input  logic              por_trip_in,
    output logic              cmp_en
);

    logic [STAT_W-1:0] cmp_sync;
    logic              capture;
    logic              restart;
    duty_code_e        code;

    // Bring both comparator levels into the clk domain (bit 1 = LVD, bit 0 = POR).
    supmon_sync #(.W(STAT_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({lvd_trip_in, por_trip_in}),
        .sync_o  (cmp_sync)
    );

    // Period counting and the enable window.
    supmon_window u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (lstick),
        .restart_i (restart),
        .code_i    (code),
        .en_o      (cmp_en),
        .capture_o (capture)
    );

    // CPU-visible trim and status registers.
    supmon_regs #(
        .ADDR_W    (ADDR_W),
        .STAT_ADDR (ADDR_W'(9'h1E4)),
        .TRIM_ADDR (ADDR_W'(9'h1EB))
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .xio_en     (xio_en),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .capture_i  (capture),
        .cmp_sync_i (cmp_sync),
        .code_o     (code),
        .restart_o  (restart)
    );

    // R9: a read with the bank flag clear returns zero.
    p_read_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && !xio_en) |-> (bus_rdata == '0));

    // R5: capture happens only while the comparators are enabled.
    p_capture_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> cmp_en);

endmodule

// File: tb/supmon_duty_ctrl_tb.sv
`timescale 1ns/1ps
module supmon_duty_ctrl_tb;

    localparam logic [8:0] A_STAT = 9'h1E4;
    localparam logic [8:0] A_TRIM = 9'h1EB;
    // Row: {code[1:0], lvd, por}
    localparam logic [3:0] VEC [6] = '{4'b10_11, 4'b11_01, 4'b00_10,
                                       4'b01_00, 4'b11_11, 4'b10_10};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lstick = 1'b0;
    logic       xio_en = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [8:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       lvd_trip_in = 1'b0;
    logic       por_trip_in = 1'b0;
    logic       cmp_en;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [7:0] exp_stat = 8'h00;

    always #2.5 clk = ~clk;

    supmon_duty_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .lstick(lstick), .xio_en(xio_en),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lvd_trip_in(lvd_trip_in), .por_trip_in(por_trip_in), .cmp_en(cmp_en)
    );

    function automatic int interval(logic [1:0] c);
        case (c)
            2'b00: return 128;
            2'b01: return 512;
            2'b10: return 32;
            default: return 8;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) lstick = 1'b1;
        @(negedge clk) lstick = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d, input logic x);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; xio_en = x;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; xio_en = 1'b1;
    endtask

    task automatic rd(input logic [8:0] a, input logic x, output logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; xio_en = x;
        #1 v = bus_rdata;
        bus_sel = 1'b0; xio_en = 1'b1;
    endtask

    // Tick n-1 times expecting cmp_en low, then once expecting it high.
    task automatic run_to_window(input int n, input string tag);
        bit early = 1'b0;
        for (int i = 1; i < n; i++) begin
            tick();
            if (cmp_en) early = 1'b1;
        end
        chk(!early, {tag, " enable low before interval end"}, early, 0);
        tick();
        chk(cmp_en === 1'b1, {tag, " enable high at interval end"}, cmp_en, 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(A_TRIM, 1'b1, v); chk(v == 8'h00, "R1 trim reset", v, 8'h00);
        rd(A_STAT, 1'b1, v); chk(v == 8'h00, "R1 status reset", v, 8'h00);
        chk(cmp_en === 1'b0, "R1 enable low after reset", cmp_en, 0);

        // R3: first enable after 128 ticks with the reset code
        run_to_window(128, "R3");
        tick();
        chk(cmp_en === 1'b0, "R2 window lasts one period", cmp_en, 0);

        // R10: unmapped address reads zero
        rd(9'h1E5, 1'b1, v); chk(v == 8'h00, "R10 unmapped read", v, 8'h00);

        // R7: reserved bits read zero
        wr(A_TRIM, 8'hFF, 1'b1);
        rd(A_TRIM, 1'b1, v); chk(v == 8'hC0, "R7 reserved bits", v, 8'hC0);

        // R9: write with flag clear ignored, read with flag clear is zero
        wr(A_TRIM, 8'h40, 1'b0);
        rd(A_TRIM, 1'b1, v); chk(v == 8'hC0, "R9 gated write ignored", v, 8'hC0);
        rd(A_TRIM, 1'b0, v); chk(v == 8'h00, "R9 gated read zero", v, 8'h00);

        // Table walk: R2 mapping, R5 capture, R6 hold
        for (int r = 0; r < 6; r++) begin
            logic [1:0] c;
            logic [7:0] nxt;
            c = VEC[r][3:2];
            wr(A_TRIM, {c, 6'b0}, 1'b1);
            lvd_trip_in = VEC[r][1];
            por_trip_in = VEC[r][0];
            nxt = {6'b0, VEC[r][1:0]};
            run_to_window(interval(c), $sformatf("R2 row%0d", r));
            rd(A_STAT, 1'b1, v);
            chk(v == exp_stat, "R6 status held before window close", v, exp_stat);
            tick();
            rd(A_STAT, 1'b1, v);
            chk(v == nxt, "R5 status captured at window close", v, nxt);
            chk(cmp_en === 1'b0, "R2 window closed", cmp_en, 0);
            exp_stat = nxt;
        end

        // R8: status is read-only
        wr(A_STAT, 8'h00, 1'b1);
        rd(A_STAT, 1'b1, v); chk(v == exp_stat, "R8 status write ignored", v, exp_stat);

        // R4: restart during an open window, no capture
        wr(A_TRIM, 8'hC0, 1'b1);
        run_to_window(8, "R4 pre");
        lvd_trip_in = 1'b0; por_trip_in = 1'b1;
        wr(A_TRIM, 8'hC0, 1'b1);
        chk(cmp_en === 1'b0, "R4 write closes window", cmp_en, 0);
        tick();
        rd(A_STAT, 1'b1, v); chk(v == exp_stat, "R4 no capture after restart", v, exp_stat);
        run_to_window(7, "R4 restart");

        // R11: change one clock before the closing tick is not captured
        tick();
        exp_stat = 8'h01;
        rd(A_STAT, 1'b1, v); chk(v == exp_stat, "R5 restart window capture", v, exp_stat);
        for (int i = 1; i < 8; i++) tick();
        @(negedge clk);
        chk(cmp_en === 1'b1, "R11 window open", cmp_en, 1);
        lvd_trip_in = 1'b1; por_trip_in = 1'b0;
        @(negedge clk) lstick = 1'b1;
        @(negedge clk) lstick = 1'b0;
        rd(A_STAT, 1'b1, v); chk(v == 8'h01, "R11 late change not captured", v, 8'h01);
        for (int i = 0; i < 8; i++) tick();
        tick();
        rd(A_STAT, 1'b1, v); chk(v == 8'h02, "R11 captured next window", v, 8'h02);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule